// File: doc/BRIEF.md
# Bit-Slice Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit built from identical one-bit slices, eight of them by default. A two-bit function code picks one of four results: bitwise AND, bitwise OR, the complement of the second operand, or the binary sum of both operands. Each slice contains its own full adder. The carries ripple from each slice into the next more significant one.

Three operand controls sit in front of the logic and the adder. Each operand can be forced to zero separately, and the first operand can be replaced by its one's complement. A carry seed input feeds the carry into the least significant slice, so the block can produce A+1, A+B+1 and, with the first operand inverted, B−A. The carry out of the most significant slice is exported for the sum function only.

Top module: `bitslice_alu`

## Requirements
- R1: With function code {fn_hi,fn_lo} = 00, result equals the bitwise AND of the conditioned operands.
- R2: With code 01, result equals the bitwise OR of the conditioned operands.
- R3: With code 10, result equals the complement of the conditioned second operand. When pass_b=0 this is all ones.
- R4: With code 11, {carry_out,result} equals conditioned A plus conditioned B plus carry_seed, taken as a WIDTH+1-bit sum.
- R5: When pass_a=0, the first operand is treated as zero before flip_a is applied and before the logic and adder stages.
- R6: When pass_b=0, the second operand is treated as zero before the logic and adder stages.
- R7: When flip_a=1, the conditioned first operand is the complement of the gated op_a. With flip_a=1, carry_seed=1 and code 11, result is op_b − op_a modulo 2^WIDTH.
- R8: carry_seed has no effect on result for codes 00, 01 and 10.
- R9: carry_out is 0 for codes 00, 01 and 10.
- R10: The function decoder asserts exactly one of its four enables for every code, so each code yields exactly its own function and no mixture of functions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| fn_hi | input | 1 | Function code, more significant bit |
| fn_lo | input | 1 | Function code, less significant bit |
| pass_a | input | 1 | 1 passes op_a, 0 forces it to zero |
| pass_b | input | 1 | 1 passes op_b, 0 forces it to zero |
| flip_a | input | 1 | 1 complements the first operand |
| carry_seed | input | 1 | Carry into the least significant slice |
| result | output | WIDTH | Selected function result |
| carry_out | output | 1 | Carry from the top slice for the sum, else 0 |

## Verification
The hardest case to reach is a carry that ripples through every slice while the operand controls reshape the operands. Examples are an all-ones conditioned operand plus the carry seed, and a subtraction built from inversion plus seed, where the top carry flags "no borrow". The stimulus crosses every function code with all sixteen control combinations over operand patterns that include all-ones, alternating bits and single set bits. Directed subtraction cases then cover equal, smaller and larger operands.

// File: rtl/bitslice_alu_pkg.sv
package bitslice_alu_pkg;

    localparam int FN_COUNT = 4;
    localparam int FN_BITS  = $clog2(FN_COUNT);

    typedef enum logic [FN_BITS-1:0] {
        FN_AND  = 2'b00,
        FN_OR   = 2'b01,
        FN_NOTB = 2'b10,
        FN_SUM  = 2'b11
    } alu_fn_e;

    // Per-slice working values, filled by one combinational process.
    typedef struct packed {
        logic a_cond;
        logic b_cond;
        logic and_v;
        logic or_v;
        logic notb_v;
        logic sum_v;
        logic res;
    } slice_sig_t;

endpackage

// File: rtl/fn_decoder.sv
module fn_decoder
    import bitslice_alu_pkg::*;
(
    input  logic [FN_BITS-1:0]  code,
    output logic [FN_COUNT-1:0] en
);
    for (genvar gi = 0; gi < FN_COUNT; gi++) begin : g_line
        assign en[gi] = (code == FN_BITS'(gi));
    end
endmodule

// File: rtl/full_adder.sv
module full_adder (
    input  logic a_in,
    input  logic b_in,
    input  logic c_in,
    output logic s_out,
    output logic c_out
);
    logic half_x;
    assign half_x = a_in ^ b_in;
    assign s_out  = half_x ^ c_in;
    assign c_out  = (a_in & b_in) | (half_x & c_in);
endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
    import bitslice_alu_pkg::*;
(
    input  logic                a_bit,
    input  logic                b_bit,
    input  logic                pass_a,
    input  logic                pass_b,
    input  logic                flip_a,
    input  logic [FN_COUNT-1:0] fn_en,
    input  logic                carry_in,
    output logic                carry_out,
    output logic                res_bit
);
    slice_sig_t sig_d;
    logic       sum_bit;

    // The adder sees the conditioned operands.
    full_adder u_fa (
        .a_in  (sig_d.a_cond),
        .b_in  (sig_d.b_cond),
        .c_in  (carry_in),
        .s_out (sum_bit),
        .c_out (carry_out)
    );

    always_comb begin
        sig_d        = '0;
        sig_d.a_cond = (a_bit & pass_a) ^ flip_a;
        sig_d.b_cond = b_bit & pass_b;
        sig_d.and_v  = sig_d.a_cond & sig_d.b_cond;
        sig_d.or_v   = sig_d.a_cond | sig_d.b_cond;
        sig_d.notb_v = ~sig_d.b_cond;
        sig_d.sum_v  = sum_bit;
        sig_d.res    = (fn_en[FN_AND]  & sig_d.and_v)
                     | (fn_en[FN_OR]   & sig_d.or_v)
                     | (fn_en[FN_NOTB] & sig_d.notb_v)
                     | (fn_en[FN_SUM]  & sig_d.sum_v);
    end

    assign res_bit = sig_d.res;
endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
    import bitslice_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             fn_hi,
    input  logic             fn_lo,
    input  logic             pass_a,
    input  logic             pass_b,
    input  logic             flip_a,
    input  logic             carry_seed,
    output logic [WIDTH-1:0] result,
    output logic             carry_out
);
    localparam int CHAIN_LEN = WIDTH + 1;

    logic [FN_COUNT-1:0]  fn_en;
    logic [CHAIN_LEN-1:0] chain;

    fn_decoder u_dec (
        .code ({fn_hi, fn_lo}),
        .en   (fn_en)
    );

    assign chain[0] = carry_seed;

    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_slice
        alu_bit_slice u_slice (
            .a_bit     (op_a[gi]),
            .b_bit     (op_b[gi]),
            .pass_a    (pass_a),
            .pass_b    (pass_b),
            .flip_a    (flip_a),
            .fn_en     (fn_en),
            .carry_in  (chain[gi]),
            .carry_out (chain[gi+1]),
            .res_bit   (result[gi])
        );
    end

    // The top carry is exported only while the sum is selected.
    assign carry_out = fn_en[FN_SUM] & chain[WIDTH];
endmodule

// File: rtl/bitslice_alu_checker.sv
module bitslice_alu_checker
    import bitslice_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic [WIDTH-1:0]    op_a,
    input logic [WIDTH-1:0]    op_b,
    input logic                fn_hi,
    input logic                fn_lo,
    input logic                pass_a,
    input logic                pass_b,
    input logic                flip_a,
    input logic                carry_seed,
    input logic [WIDTH-1:0]    result,
    input logic                carry_out,
    input logic [FN_COUNT-1:0] fn_en
);
    logic [WIDTH-1:0] a_chk;
    logic [WIDTH-1:0] b_chk;
    logic [WIDTH:0]   sum_chk;
    logic [1:0]       code_chk;

    always_comb begin
        a_chk    = (pass_a ? op_a : '0) ^ {WIDTH{flip_a}};
        b_chk    = pass_b ? op_b : '0;
        sum_chk  = {1'b0, a_chk} + {1'b0, b_chk} + {{WIDTH{1'b0}}, carry_seed};
        code_chk = {fn_hi, fn_lo};

        p_one_enable_r10: assert ($countones(fn_en) == 1)
            else $error("decoder enables not one-hot: %b", fn_en);
        if (code_chk == 2'b00) begin
            p_and_r1: assert (result == (a_chk & b_chk))
                else $error("AND result %h", result);
        end
        if (code_chk == 2'b01) begin
            p_or_r2: assert (result == (a_chk | b_chk))
                else $error("OR result %h", result);
        end
        if (code_chk == 2'b10) begin
            p_notb_r3: assert (result == ~b_chk)
                else $error("NOT B result %h", result);
        end
        if (code_chk == 2'b11) begin
            p_sum_r4: assert ({carry_out, result} == sum_chk)
                else $error("sum %h carry %b", result, carry_out);
        end else begin
            p_no_carry_r9: assert (carry_out == 1'b0)
                else $error("carry out set for a logic function");
        end
    end
endmodule

bind bitslice_alu bitslice_alu_checker #(.WIDTH(WIDTH)) u_chk (
    .op_a       (op_a),
    .op_b       (op_b),
    .fn_hi      (fn_hi),
    .fn_lo      (fn_lo),
    .pass_a     (pass_a),
    .pass_b     (pass_b),
    .flip_a     (flip_a),
    .carry_seed (carry_seed),
    .result     (result),
    .carry_out  (carry_out),
    .fn_en      (fn_en)
);

// File: tb/bitslice_alu_bench.sv
`timescale 1ns/1ps
module bitslice_alu_bench;
    localparam int W = 8;

    typedef struct {
        logic [W-1:0] res;
        logic         co;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] op_a = '0, op_b = '0;
    logic         fn_hi = 0, fn_lo = 0, pass_a = 0, pass_b = 0, flip_a = 0, carry_seed = 0;
    logic [W-1:0] result;
    logic         carry_out;

    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    bitslice_alu #(.WIDTH(W)) u_bitslice_alu (
        .op_a(op_a), .op_b(op_b), .fn_hi(fn_hi), .fn_lo(fn_lo),
        .pass_a(pass_a), .pass_b(pass_b), .flip_a(flip_a),
        .carry_seed(carry_seed), .result(result), .carry_out(carry_out)
    );

    // Reference model built from the requirements.
    function automatic exp_t model(input logic [W-1:0] a, input logic [W-1:0] b,
                                   input logic [1:0] fn, input logic pa, input logic pb,
                                   input logic fa, input logic ci, input string tag);
        exp_t         e;
        logic [W-1:0] ac, bc;
        logic [W:0]   s;
        ac = (pa ? a : '0);
        if (fa) ac = ~ac;
        bc = pb ? b : '0;
        s  = {1'b0, ac} + {1'b0, bc} + {{W{1'b0}}, ci};
        e.co = 1'b0;
        case (fn)
            2'b00:   e.res = ac & bc;
            2'b01:   e.res = ac | bc;
            2'b10:   e.res = ~bc;
            default: begin e.res = s[W-1:0]; e.co = s[W]; end
        endcase
        e.tag = tag;
        return e;
    endfunction

    // Driver: apply at the falling edge, queue the expectation.
    task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic [1:0] fn,
                         input logic pa, input logic pb, input logic fa, input logic ci,
                         input string tag);
        @(negedge clk);
        op_a = a; op_b = b; {fn_hi, fn_lo} = fn;
        pass_a = pa; pass_b = pb; flip_a = fa; carry_seed = ci;
        sb_q.push_back(model(a, b, fn, pa, pb, fa, ci, tag));
    endtask

    // Driver with an explicit expectation, for hand-worked cases.
    task automatic drive_exp(input logic [W-1:0] a, input logic [W-1:0] b, input logic [1:0] fn,
                             input logic pa, input logic pb, input logic fa, input logic ci,
                             input logic [W-1:0] er, input logic ec, input string tag);
        exp_t e;
        @(negedge clk);
        op_a = a; op_b = b; {fn_hi, fn_lo} = fn;
        pass_a = pa; pass_b = pb; flip_a = fa; carry_seed = ci;
        e.res = er; e.co = ec; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compare at the rising edge, half a cycle after the drive.
    always @(posedge clk) begin
        if (!rst && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (result !== e.res || carry_out !== e.co) begin
                errors++;
                $display("FAIL %s: result=%h carry=%b expected result=%h carry=%b",
                         e.tag, result, carry_out, e.res, e.co);
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: done=0 expected done=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [W-1:0] pats [8];
        pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hAA; pats[3] = 8'h55;
        pats[4] = 8'h01; pats[5] = 8'h80; pats[6] = 8'h3C; pats[7] = 8'hC7;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // Idle state: all inputs zero selects AND of zeros.
        drive(8'h00, 8'h00, 2'b00, 0, 0, 0, 0, "R1 idle");

        // Every code crossed with every control combination.
        for (int f = 0; f < 4; f++) begin
            for (int c = 0; c < 16; c++) begin
                for (int p = 0; p < 8; p++) begin
                    string t;
                    case (f)
                        0: t = "R1 and";
                        1: t = "R2 or";
                        2: t = "R3 notb";
                        default: t = "R4 sum";
                    endcase
                    drive(pats[p], pats[(p + 3) % 8], 2'(f),
                          c[0], c[1], c[2], c[3], t);
                end
            end
        end

        // R5: first operand gated to zero.
        drive_exp(8'hF0, 8'h0F, 2'b01, 0, 1, 0, 0, 8'h0F, 0, "R5 gate a");
        drive_exp(8'hFF, 8'h12, 2'b11, 0, 1, 0, 0, 8'h12, 0, "R5 gate a sum");
        // R6: second operand gated; NOT B becomes all ones.
        drive_exp(8'h33, 8'hA5, 2'b10, 1, 0, 0, 0, 8'hFF, 0, "R6 gate b");
        drive_exp(8'h33, 8'hFF, 2'b00, 1, 0, 0, 0, 8'h00, 0, "R6 gate b and");
        // R7: subtraction B-A via inversion and carry seed.
        drive_exp(8'h05, 8'h0C, 2'b11, 1, 1, 1, 1, 8'h07, 1, "R7 b minus a");
        drive_exp(8'h0C, 8'h05, 2'b11, 1, 1, 1, 1, 8'hF9, 0, "R7 borrow");
        drive_exp(8'h42, 8'h42, 2'b11, 1, 1, 1, 1, 8'h00, 1, "R7 equal");
        drive_exp(8'h00, 8'h00, 2'b11, 0, 1, 1, 0, 8'hFF, 0, "R7 invert zero");
        // R4: full ripple through every slice.
        drive_exp(8'hFF, 8'h00, 2'b11, 1, 1, 0, 1, 8'h00, 1, "R4 ripple");
        drive_exp(8'hFF, 8'hFF, 2'b11, 1, 1, 0, 1, 8'hFF, 1, "R4 max");
        // R8: carry seed leaves logic results untouched.
        drive_exp(8'hC3, 8'h5A, 2'b00, 1, 1, 0, 1, 8'h42, 0, "R8 and seed");
        drive_exp(8'hC3, 8'h5A, 2'b01, 1, 1, 0, 1, 8'hDB, 0, "R8 or seed");
        drive_exp(8'hC3, 8'h5A, 2'b10, 1, 1, 0, 1, 8'hA5, 0, "R8 notb seed");
        // R9: an overflowing pair under a logic code gives no carry.
        drive_exp(8'hFF, 8'hFF, 2'b01, 1, 1, 0, 1, 8'hFF, 0, "R9 no carry");
        // R10: same operands, each code alone.
        drive_exp(8'h6C, 8'h3A, 2'b00, 1, 1, 0, 0, 8'h28, 0, "R10 code0");
        drive_exp(8'h6C, 8'h3A, 2'b01, 1, 1, 0, 0, 8'h7E, 0, "R10 code1");
        drive_exp(8'h6C, 8'h3A, 2'b10, 1, 1, 0, 0, 8'hC5, 0, "R10 code2");
        drive_exp(8'h6C, 8'h3A, 2'b11, 1, 1, 0, 0, 8'hA6, 0, "R10 code3");

        repeat (3) @(posedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule